// File: doc/BRIEF.md
# Dual-Role Serial Peripheral Port

This block is a full-duplex, byte-wide SPI port that can act as the bus master or as a slave, depending on a single mode input. Every byte moves eight bits each way at once, most significant bit first. Clock polarity and clock phase are selectable. In any one setting, data is launched on one serial clock edge and captured on the opposite edge. Both ends of a link must use the same polarity and phase.

As master, the port builds the serial clock from the system clock with a programmable divider. It drives MOSI, samples MISO, and lowers its own active-low chip select around each byte. A new byte is accepted only while the port is not busy.

As slave, the port takes the serial clock, MOSI and chip select from an external master. These inputs pass through two-flop synchronisers and their edges are found in the system clock domain. The port keeps exchanging bytes for as long as chip select stays low. It drives MISO only while it is selected. A one-cycle done pulse marks each finished byte, and the received byte is held in a read register.

In slave mode the MISO reply lags the driving serial clock edge by three system clocks. A peer master therefore needs a half period of at least four system clocks.

Top module: `spi_duplex_port`

## Requirements
- R1: Each byte exchanges 8 bits in both directions at once, MSB first. The byte captured at one end equals the byte that the other end loaded into `tx_data`.
- R2: In master mode SCLK toggles every DIV+1 system clocks, where DIV is `cfg_div`. This gives a serial clock period of 2 × (DIV+1) system clocks.
- R3: A master byte has exactly 16 SCLK transitions (eight periods). Chip select stays low for 17 × (DIV+1) system clocks. The extra half period follows the last edge.
- R4: SCLK rests at `cfg_cpol` when idle. With `cfg_cpha`=0, data is captured on the leading edge and launched on the trailing edge. With `cfg_cpha`=1, data is launched on the leading edge and captured on the trailing edge. All four combinations work.
- R5: In master mode `cs_n_o` goes low on the clock edge that accepts `tx_start` and high once the byte ends. `busy` is high for exactly that span. A `tx_start` pulse while `busy` is high is ignored: it does not start a second byte and does not change the byte being sent.
- R6: In slave mode a falling `cs_n_i` starts a byte. Further bytes follow back to back while `cs_n_i` stays low, and each one raises its own done pulse. `tx_data` is sampled at each byte boundary.
- R7: In slave mode a rising `cs_n_i` in the middle of a byte throws the partial byte away: no done pulse is raised. The next selection starts again from bit 7.
- R8: `miso_oe` is low whenever the slave is deselected. `pins_oe` (the enable for SCLK, MOSI and chip select) equals `cfg_master`.
- R9: `rx_done` is a single-cycle pulse that follows the final capture edge of a byte. `rx_data` holds that byte until the next pulse.
- R10: With `cfg_cpha`=0, the first data bit (tx_data bit 7) is present on the data output as soon as chip select goes low, before any SCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_cpol | input | 1 | Idle level of SCLK |
| cfg_cpha | input | 1 | 0 = capture on leading edge, 1 = launch on leading edge |
| cfg_div | input | DIV_W | Master divider value DIV |
| tx_data | input | DATA_W | Byte to transmit |
| tx_start | input | 1 | Master start request (ignored while busy or in slave mode) |
| rx_data | output | DATA_W | Last received byte |
| rx_done | output | 1 | One-cycle byte-complete pulse |
| busy | output | 1 | Master byte in progress / slave selected |
| pins_oe | output | 1 | Output enable for SCLK, MOSI and chip select |
| sclk_o | output | 1 | Master serial clock |
| sclk_i | input | 1 | Slave serial clock |
| mosi_o | output | 1 | Master data out |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data out enable |
| miso_i | input | 1 | Master data in |
| cs_n_o | output | 1 | Master active-low chip select |
| cs_n_i | input | 1 | Slave active-low chip select |

## Verification
The hardest slave situations to reach are two bytes back to back under one chip select, and chip select rising after only part of a byte. A master built from this same block always frames exactly one byte, so it can never produce either case. The bench therefore takes over the slave's pins with a bit-banged master that can hold chip select across two bytes, or cut a byte short after four bits. It then checks the done count, the captured bytes and the returned MISO bits. Every master run is looped back into a second instance used as a slave. This way the divider timing, the framing and all four polarity/phase settings are checked from both ends at once.

// File: rtl/spi_duplex_pkg.sv
package spi_duplex_pkg;

    typedef struct packed {
        logic master;
        logic cpol;
        logic cpha;
    } spi_cfg_t;

    typedef struct packed {
        logic start;
        logic lead;
        logic trail;
        logic abort;
    } spi_ev_t;

    typedef enum logic {
        TMR_IDLE = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_e;

    function automatic logic is_lead(input logic cpol, input logic prev, input logic cur);
        return cpol ? (prev & ~cur) : (~prev & cur);
    endfunction

    function automatic logic is_trail(input logic cpol, input logic prev, input logic cur);
        return cpol ? (~prev & cur) : (prev & ~cur);
    endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        logic [W-1:0] r;
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) r <= RST_VAL;
                else     r <= g_stage[g-1].r;
            end
        end
    end

    assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spi_master_timer.sv
module spi_master_timer
    import spi_duplex_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cpol,
    input  logic [DIV_W-1:0] div,
    input  logic             req,
    output logic             sclk,
    output logic             cs_n,
    output logic             busy,
    output spi_ev_t          ev
);
    localparam int EDGES = 2 * DATA_W;
    localparam int EW    = $clog2(EDGES + 1);

    tmr_state_e       state;
    logic [DIV_W-1:0] cnt;
    logic [EW-1:0]    edg;
    logic             sclk_q;
    logic             cs_q;
    logic             tick;
    logic             accept;
    logic             more;

    assign tick   = (state == TMR_RUN) && (cnt == div);
    assign accept = en && req && (state == TMR_IDLE);
    assign more   = edg < EW'(EDGES);

    always_comb begin
        ev.start = accept;
        ev.lead  = tick && more && !edg[0];
        ev.trail = tick && more &&  edg[0];
        ev.abort = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= TMR_IDLE;
            cnt    <= '0;
            edg    <= '0;
            sclk_q <= cpol;
            cs_q   <= 1'b1;
        end else begin
            case (state)
                TMR_IDLE: begin
                    sclk_q <= cpol;
                    cs_q   <= 1'b1;
                    if (accept) begin
                        state <= TMR_RUN;
                        cs_q  <= 1'b0;
                        cnt   <= '0;
                        edg   <= '0;
                    end
                end
                default: begin
                    if (tick) begin
                        cnt <= '0;
                        if (more) begin
                            sclk_q <= ~sclk_q;
                            edg    <= edg + 1'b1;
                        end else begin
                            state <= TMR_IDLE;
                            cs_q  <= 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end

    assign sclk = sclk_q;
    assign cs_n = cs_q;
    assign busy = (state == TMR_RUN);

    // R4: idle clock level follows polarity
    p_idle_level_r4: assert property (@(posedge clk) disable iff (rst)
        (state == TMR_IDLE && $past(state == TMR_IDLE)) |-> (sclk_q == $past(cpol)));

    // R2: a clock transition only ever follows a full divider count
    p_edge_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        (state == TMR_RUN && $past(state == TMR_RUN) && sclk_q != $past(sclk_q))
        |-> ($past(cnt) == $past(div)));
endmodule

// File: rtl/spi_slave_front.sv
module spi_slave_front
    import spi_duplex_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    cpol,
    input  logic    sclk_i,
    input  logic    mosi_i,
    input  logic    cs_n_i,
    output spi_ev_t ev,
    output logic    sdi,
    output logic    selected
);
    logic [2:0] sync_q;
    logic       sclk_s, cs_s;
    logic       p_sclk, p_cs;

    spi_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n_i, sclk_i, mosi_i}),
        .q   (sync_q)
    );

    assign cs_s   = sync_q[2];
    assign sclk_s = sync_q[1];
    assign sdi    = sync_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            p_sclk <= 1'b0;
            p_cs   <= 1'b1;
        end else begin
            p_sclk <= sclk_s;
            p_cs   <= cs_s;
        end
    end

    assign selected = en && !cs_s;

    always_comb begin
        ev.start = en &&  p_cs && !cs_s;
        ev.abort = en && !p_cs &&  cs_s;
        ev.lead  = en && !p_cs && !cs_s && is_lead(cpol, p_sclk, sclk_s);
        ev.trail = en && !p_cs && !cs_s && is_trail(cpol, p_sclk, sclk_s);
    end
endmodule

// File: rtl/spi_bit_engine.sv
module spi_bit_engine
    import spi_duplex_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpha,
    input  spi_ev_t           ev,
    input  logic              sdi,
    input  logic [DATA_W-1:0] tx_data,
    output logic              sdo,
    output logic [DATA_W-1:0] rx_data,
    output logic              done
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] sh, sh_smp, rx_q;
    logic [CW-1:0]     bitn;
    logic              sdo_q, done_q;
    logic              sample_ev, drive_ev, last;

    always_comb begin
        sample_ev = cpha ? ev.trail : ev.lead;
        last      = ev.trail && (bitn == CW'(DATA_W - 1));
        drive_ev  = cpha ? ev.lead : (ev.trail && !last);
        sh_smp    = sample_ev ? {sh[DATA_W-1:1], sdi} : sh;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            rx_q   <= '0;
            bitn   <= '0;
            sdo_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (ev.abort) begin
                bitn <= '0;
            end else if (ev.start || last) begin
                if (last) begin
                    rx_q   <= sh_smp;
                    done_q <= 1'b1;
                end
                bitn <= '0;
                if (cpha) begin
                    sh <= tx_data;
                end else begin
                    sh    <= {tx_data[DATA_W-2:0], 1'b0};
                    sdo_q <= tx_data[DATA_W-1];
                end
            end else begin
                if (ev.trail) bitn <= bitn + 1'b1;
                if (drive_ev) begin
                    sdo_q <= sh_smp[DATA_W-1];
                    sh    <= {sh_smp[DATA_W-2:0], 1'b0};
                end else begin
                    sh <= sh_smp;
                end
            end
        end
    end

    assign sdo     = sdo_q;
    assign rx_data = rx_q;
    assign done    = done_q;

    // R9: a byte completes only right after a trailing edge
    p_done_after_trail_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(ev.trail));

    // R9: completion is a single-cycle pulse
    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/spi_duplex_port.sv
module spi_duplex_port
    import spi_duplex_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_master,
    input  logic              cfg_cpol,
    input  logic              cfg_cpha,
    input  logic [DIV_W-1:0]  cfg_div,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_start,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_done,
    output logic              busy,
    output logic              pins_oe,
    output logic              sclk_o,
    input  logic              sclk_i,
    output logic              mosi_o,
    input  logic              mosi_i,
    output logic              miso_o,
    output logic              miso_oe,
    input  logic              miso_i,
    output logic              cs_n_o,
    input  logic              cs_n_i
);
    spi_cfg_t cfg;
    spi_ev_t  m_ev, s_ev, ev;
    logic     m_busy, s_sel, s_sdi, sdi, sdo;

    assign cfg = '{master: cfg_master, cpol: cfg_cpol, cpha: cfg_cpha};

    spi_master_timer #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .en   (cfg.master),
        .cpol (cfg.cpol),
        .div  (cfg_div),
        .req  (tx_start),
        .sclk (sclk_o),
        .cs_n (cs_n_o),
        .busy (m_busy),
        .ev   (m_ev)
    );

    spi_slave_front u_front (
        .clk      (clk),
        .rst      (rst),
        .en       (!cfg.master),
        .cpol     (cfg.cpol),
        .sclk_i   (sclk_i),
        .mosi_i   (mosi_i),
        .cs_n_i   (cs_n_i),
        .ev       (s_ev),
        .sdi      (s_sdi),
        .selected (s_sel)
    );

    assign ev  = cfg.master ? m_ev   : s_ev;
    assign sdi = cfg.master ? miso_i : s_sdi;

    spi_bit_engine #(.DATA_W(DATA_W)) u_engine (
        .clk     (clk),
        .rst     (rst),
        .cpha    (cfg.cpha),
        .ev      (ev),
        .sdi     (sdi),
        .tx_data (tx_data),
        .sdo     (sdo),
        .rx_data (rx_data),
        .done    (rx_done)
    );

    assign mosi_o  = cfg.master ? sdo : 1'b0;
    assign miso_o  = sdo;
    assign miso_oe = !cfg.master && s_sel;
    assign pins_oe = cfg.master;
    assign busy    = cfg.master ? m_busy : s_sel;

    // R8: a deselected slave leaves MISO undriven
    p_miso_released_r8: assert property (@(posedge clk) disable iff (rst)
        (!cfg_master && $past(!cfg_master) && $past(cs_n_i, 1) && $past(cs_n_i, 2))
        |-> !miso_oe);

    // R5: chip select falls together with the start of a master byte
    p_cs_frame_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && $rose(busy)) |-> !cs_n_o);

    // R5: chip select is high while an idle master waits
    p_cs_idle_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg_master && !busy && $past(!busy)) |-> cs_n_o);
endmodule

// File: tb/spi_duplex_port_tb_top.sv
module spi_duplex_port_tb_top;
    localparam int DW = 8;
    localparam int VW = 8;
    localparam int HB = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic          cpol = 1'b0, cpha = 1'b0;
    logic [VW-1:0] div = 8'd3;
    logic [DW-1:0] m_tx = '0, s_tx = '0;
    logic          m_start = 1'b0;
    logic          use_bm = 1'b0;
    logic          b_sclk = 1'b0, b_mosi = 1'b0, b_cs_n = 1'b1;

    logic [DW-1:0] m_rx, s_rx;
    logic m_done, s_done, m_busy, s_busy, m_oe, s_oe;
    logic m_sclk, m_mosi, m_miso_o, m_miso_oe, m_cs_n;
    logic s_sclk_o, s_mosi_o, s_miso, s_miso_oe, s_cs_n_o;
    logic m_miso_in, p_sclk, p_mosi, p_cs_n;

    assign m_miso_in = s_miso_oe ? s_miso : 1'b1;
    assign p_sclk = use_bm ? b_sclk : m_sclk;
    assign p_mosi = use_bm ? b_mosi : m_mosi;
    assign p_cs_n = use_bm ? b_cs_n : m_cs_n;

    spi_duplex_port #(.DATA_W(DW), .DIV_W(VW)) dut_i (
        .clk(clk), .rst(rst), .cfg_master(1'b1), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_div(div), .tx_data(m_tx), .tx_start(m_start), .rx_data(m_rx),
        .rx_done(m_done), .busy(m_busy), .pins_oe(m_oe), .sclk_o(m_sclk),
        .sclk_i(1'b0), .mosi_o(m_mosi), .mosi_i(1'b0), .miso_o(m_miso_o),
        .miso_oe(m_miso_oe), .miso_i(m_miso_in), .cs_n_o(m_cs_n), .cs_n_i(1'b1)
    );

    spi_duplex_port #(.DATA_W(DW), .DIV_W(VW)) peer_i (
        .clk(clk), .rst(rst), .cfg_master(1'b0), .cfg_cpol(cpol), .cfg_cpha(cpha),
        .cfg_div(div), .tx_data(s_tx), .tx_start(1'b0), .rx_data(s_rx),
        .rx_done(s_done), .busy(s_busy), .pins_oe(s_oe), .sclk_o(s_sclk_o),
        .sclk_i(p_sclk), .mosi_o(s_mosi_o), .mosi_i(p_mosi), .miso_o(s_miso),
        .miso_oe(s_miso_oe), .miso_i(1'b0), .cs_n_o(s_cs_n_o), .cs_n_i(p_cs_n)
    );

    int errors = 0, checks = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // monitor
    logic clr = 1'b0;
    int   cyc = 0, m_dn = 0, s_dn = 0, cs_low = 0, toggles = 0, t0 = 0, t1 = 0;
    logic prev_sclk = 1'b0;
    logic [DW-1:0] m_rx_last = '0, s_rx_first = '0, s_rx_last = '0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        prev_sclk <= m_sclk;
        if (clr) begin
            m_dn <= 0; s_dn <= 0; cs_low <= 0; toggles <= 0;
        end else begin
            if (m_done) begin m_dn <= m_dn + 1; m_rx_last <= m_rx; end
            if (s_done) begin
                s_dn <= s_dn + 1;
                if (s_dn == 0) s_rx_first <= s_rx;
                s_rx_last <= s_rx;
            end
            if (!m_cs_n) cs_low <= cs_low + 1;
            if (m_sclk != prev_sclk) begin
                toggles <= toggles + 1;
                if (toggles == 0) t0 <= cyc;
                if (toggles == 1) t1 <= cyc;
            end
        end
    end

    task automatic clear_mon();
        clr = 1'b1;
        repeat (2) @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic master_run(input logic pol, input logic pha, input int dv,
                              input logic [DW-1:0] mt, input logic [DW-1:0] st,
                              input bit poke);
        int guard;
        use_bm = 1'b0;
        cpol = pol; cpha = pha; div = VW'(dv);
        m_tx = mt; s_tx = st;
        repeat (8) @(negedge clk);
        chk(m_sclk == pol, "R4", "idle sclk", m_sclk, pol);
        chk(m_cs_n == 1'b1 && !m_busy, "R5", "idle cs_n", m_cs_n, 1);
        clear_mon();
        m_start = 1'b1;
        @(negedge clk);
        m_start = 1'b0;
        chk(m_cs_n == 1'b0 && m_busy, "R5", "cs_n after start", m_cs_n, 0);
        if (!pha) chk(m_mosi == mt[DW-1], "R10", "first bit before edge", m_mosi, mt[DW-1]);
        if (poke) begin
            repeat (40) @(negedge clk);
            m_tx = ~mt;
            m_start = 1'b1;
            @(negedge clk);
            m_start = 1'b0;
        end
        guard = 0;
        while (m_busy && guard < 4000) begin @(negedge clk); guard++; end
        repeat (10) @(negedge clk);
        chk(m_rx_last == st, "R1", "master rx", m_rx_last, st);
        chk(s_rx_last == mt, "R1", "slave rx", s_rx_last, mt);
        chk(toggles == 2 * DW, "R3", "sclk transitions", toggles, 2 * DW);
        chk(cs_low == 17 * (dv + 1), "R3", "cs low cycles", cs_low, 17 * (dv + 1));
        chk(t1 - t0 == dv + 1, "R2", "half period", t1 - t0, dv + 1);
        chk(m_dn == 1 && s_dn == 1, "R9", "done pulses", m_dn * 16 + s_dn, 17);
        if (poke) chk(m_dn == 1 && s_rx_last == mt, "R5", "start while busy ignored",
                      s_rx_last, mt);
    endtask

    task automatic bm_byte(input logic [DW-1:0] o, input int nbits,
                           output logic [DW-1:0] got);
        got = '0;
        for (int i = DW - 1; i > DW - 1 - nbits; i--) begin
            if (!cpha) begin
                b_mosi = o[i];
                repeat (HB) @(negedge clk);
                got[i] = s_miso;
                b_sclk = ~b_sclk;
                repeat (HB) @(negedge clk);
                b_sclk = ~b_sclk;
            end else begin
                b_sclk = ~b_sclk;
                b_mosi = o[i];
                repeat (HB) @(negedge clk);
                got[i] = s_miso;
                b_sclk = ~b_sclk;
                repeat (HB) @(negedge clk);
            end
        end
    endtask

    task automatic slave_run(input logic pol, input logic pha, input logic [DW-1:0] b0,
                             input logic [DW-1:0] b1, input logic [DW-1:0] st);
        logic [DW-1:0] g0, g1;
        use_bm = 1'b1;
        cpol = pol; cpha = pha; s_tx = st;
        b_sclk = pol; b_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(!s_miso_oe, "R8", "miso_oe while deselected", s_miso_oe, 0);
        chk(s_oe == 1'b0 && m_oe == 1'b1, "R8", "pins_oe by role", {m_oe, s_oe}, 2);
        clear_mon();
        b_cs_n = 1'b0;
        repeat (HB) @(negedge clk);
        chk(s_miso_oe, "R8", "miso_oe while selected", s_miso_oe, 1);
        bm_byte(b0, DW, g0);
        bm_byte(b1, DW, g1);
        repeat (HB) @(negedge clk);
        b_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(s_dn == 2, "R6", "back-to-back done count", s_dn, 2);
        chk(s_rx_first == b0, "R6", "first byte", s_rx_first, b0);
        chk(s_rx_last == b1, "R6", "second byte", s_rx_last, b1);
        chk(g0 == st && g1 == st, "R1", "slave miso bytes", {g0, g1}, {st, st});
        chk(!s_miso_oe, "R8", "miso_oe after deselect", s_miso_oe, 0);
        // R7: cut a byte after four bits, then a full byte
        clear_mon();
        b_cs_n = 1'b0;
        repeat (HB) @(negedge clk);
        bm_byte(~b1, 4, g0);
        repeat (HB) @(negedge clk);
        b_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(s_dn == 0, "R7", "no done on partial byte", s_dn, 0);
        b_cs_n = 1'b0;
        repeat (HB) @(negedge clk);
        bm_byte(b0, DW, g1);
        repeat (HB) @(negedge clk);
        b_cs_n = 1'b1;
        repeat (8) @(negedge clk);
        chk(s_dn == 1 && s_rx_last == b0, "R7", "byte after abort", s_rx_last, b0);
        chk(g1 == st, "R7", "miso restarts at bit 7", g1, st);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (4) @(negedge clk);
        chk(m_cs_n == 1'b1 && !m_done && !m_busy, "R5", "reset state", m_cs_n, 1);
        chk(!s_miso_oe && !s_done, "R8", "reset slave outputs", s_miso_oe, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        for (int m = 0; m < 4; m++) begin
            for (int d = 0; d < 2; d++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [DW-1:0] mt, st;
                    mt = DW'(k * 8'h5B + m);
                    st = ~mt ^ DW'(k * 3);
                    master_run(m[1], m[0], 3 + 2 * d, mt, st, k == 2);
                end
            end
        end
        for (int m = 0; m < 4; m++) begin
            slave_run(m[1], m[0], DW'(8'hA5 + m), DW'(8'h3C ^ (m * 17)), DW'(8'hC3 - m));
        end
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R5 watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule